// File: doc/BRIEF.md
# Per-CPU Interrupt Priority Arbiter

This block serves every CPU interface of an interrupt distributor. For each CPU it looks at the interrupts that are both enabled and pending for that CPU and finds the one with the most urgent priority. It then passes that candidate through two thresholds. A strict compare against the CPU's priority mask decides whether the ID is published as the highest pending interrupt. A second strict compare against the CPU's running priority decides whether the CPU's interrupt request line is raised. Register decoding, acknowledge and end-of-interrupt handling belong to the logic around this block.

The search is sequential. It examines `SCAN_W` interrupts per clock, so a full pass takes `NUM_IRQ/SCAN_W` cycles. A change on any input aborts the pass in progress and starts a new one from interrupt 0. The registered outputs keep their last committed values until the new pass ends, and `scan_done` marks the moment they are current again. All pins are plain level signals. There is no handshake, so the consumer samples `hp_id` and `irq_req` whenever it likes and uses `scan_done` to know whether they reflect the present inputs.

Top module: `irq_prio_arbiter`

## Requirements
- R1: Among the candidates for a CPU (enable bit and pending bit both 1), the one with the numerically lowest 8-bit priority is chosen. This holds for any interrupt number from 0 to NUM_IRQ-1.
- R2: When candidates share the lowest priority value, the one with the lowest interrupt number is chosen.
- R3: An interrupt that is pending but not enabled is not a candidate. When a CPU has no candidate, its `hp_id` is 1023 and its `irq_req` is 0.
- R4: One clock edge after `dist_en` or that CPU's `cpu_if_en` is seen low, the CPU's `hp_id` is 1023 and its `irq_req` is 0. They stay that way while the enable is low.
- R5: The winner's ID is published on `hp_id` only if its priority is strictly less than that CPU's 8-bit priority mask. Otherwise `hp_id` is 1023 and `irq_req` is 0.
- R6: `irq_req` is 1 only when an ID is published and the winner's priority is strictly less than the CPU's 9-bit running priority.
- R7: A running priority of 0x100 means nothing is active, so any published winner raises `irq_req`.
- R8: After a change on any input, `scan_done` goes low at the next edge. It returns high, with fresh results, exactly NUM_IRQ/SCAN_W+1 edges after the change.
- R9: While a pass is in progress and the CPU is enabled, `hp_id` and `irq_req` hold the values from the previous pass.
- R10: Each CPU is judged only on its own enable bits, pending bits, interface enable, mask and running priority. The priorities are shared by all CPUs.
- R11: After reset, every `hp_id` is 1023 and every `irq_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dist_en | input | 1 | Global distributor enable |
| cpu_if_en | input | NUM_CPU | Per-CPU interface enable |
| irq_enable | input | NUM_CPU*NUM_IRQ | Enable bits; bit c*NUM_IRQ+i is interrupt i for CPU c |
| irq_pending | input | NUM_CPU*NUM_IRQ | Pending bits, same layout as irq_enable |
| irq_prio | input | NUM_IRQ*8 | Priority of interrupt i in bits [i*8 +: 8]; lower is more urgent |
| prio_mask | input | NUM_CPU*8 | Priority mask of CPU c in bits [c*8 +: 8] |
| run_prio | input | NUM_CPU*9 | Running priority of CPU c in bits [c*9 +: 9]; 0x100 means idle |
| hp_id | output | NUM_CPU*10 | Highest pending ID of CPU c in bits [c*10 +: 10]; 1023 means none |
| irq_req | output | NUM_CPU | Registered interrupt request line per CPU |
| scan_done | output | NUM_CPU | High when the outputs reflect the current inputs |

## Verification
The hardest state to reach from the ports is the middle of a pass. That is where the outputs must hold stale values while `scan_done` is low. Every stimulus step in the bench changes at least one input, so every step forces a fresh pass. One edge after each change, the monitor compares the outputs with the previous step's results. It also counts the edges until `scan_done` returns. The threshold compares are driven exactly at equality and at one above, and the winner is placed in the last scan group so that it is only found on the final step of a pass.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int ID_W   = 10;
  localparam int PRIO_W = 8;
  localparam int RUN_W  = 9;
  localparam logic [ID_W-1:0]  NONE_ID   = 10'd1023;
  localparam logic [RUN_W-1:0] IDLE_PRIO = 9'h100;

  typedef struct packed {
    logic [RUN_W-1:0] prio;
    logic [ID_W-1:0]  id;
  } cand_t;

  localparam cand_t NO_CAND = '{prio: IDLE_PRIO, id: NONE_ID};
endpackage

// File: rtl/irq_change_detect.sv
module irq_change_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] vec,
  output logic         changed
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= vec;
  end

  assign changed = (vec != prev_q);
endmodule

// File: rtl/irq_group_pick.sv
module irq_group_pick
  import irq_arb_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0]        req,
  input  logic [LANES*PRIO_W-1:0] prio,
  input  logic [ID_W-1:0]         base_id,
  output cand_t                   best
);
  always_comb begin
    best = NO_CAND;
    for (int k = 0; k < LANES; k++) begin
      if (req[k] && ({1'b0, prio[k*PRIO_W +: PRIO_W]} < best.prio)) begin
        best.prio = {1'b0, prio[k*PRIO_W +: PRIO_W]};
        best.id   = base_id + ID_W'(k);
      end
    end
  end
endmodule

// File: rtl/irq_cpu_scan.sv
module irq_cpu_scan
  import irq_arb_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int SCAN_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      restart,
  input  logic                      gate_en,
  input  logic [NUM_IRQ-1:0]        enable,
  input  logic [NUM_IRQ-1:0]        pending,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]         mask,
  input  logic [RUN_W-1:0]          run_prio,
  output logic [ID_W-1:0]           hp_id,
  output logic                      irq_req,
  output logic                      done
);
  localparam int STEPS = NUM_IRQ / SCAN_W;
  localparam int IDX_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(STEPS - 1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  cand_t            best_q;
  cand_t            grp_best;
  cand_t            merged;
  logic [ID_W-1:0]  hp_q;
  logic             irq_q;
  logic             done_q;
  logic [NUM_IRQ-1:0] req_all;
  logic             last_step;
  logic             publish;

  assign req_all   = enable & pending;
  assign last_step = busy_q && (idx_q == LAST_IDX);

  irq_group_pick #(.LANES(SCAN_W)) pick_i (
    .req     (req_all[int'(idx_q)*SCAN_W +: SCAN_W]),
    .prio    (prio[int'(idx_q)*SCAN_W*PRIO_W +: SCAN_W*PRIO_W]),
    .base_id (ID_W'(int'(idx_q) * SCAN_W)),
    .best    (grp_best)
  );

  // earlier groups hold lower IDs, so only a strictly better group replaces
  assign merged  = (grp_best.prio < best_q.prio) ? grp_best : best_q;
  assign publish = (merged.prio < {1'b0, mask});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      best_q <= NO_CAND;
      done_q <= 1'b0;
    end else if (restart) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      best_q <= NO_CAND;
      done_q <= 1'b0;
    end else if (busy_q) begin
      best_q <= merged;
      if (last_step) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hp_q  <= NONE_ID;
      irq_q <= 1'b0;
    end else if (!gate_en) begin
      hp_q  <= NONE_ID;
      irq_q <= 1'b0;
    end else if (last_step && !restart) begin
      hp_q  <= publish ? merged.id : NONE_ID;
      irq_q <= publish && (merged.prio < run_prio);
    end
  end

  assign hp_id   = hp_q;
  assign irq_req = irq_q;
  assign done    = done_q;

  assert_disable_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |=> (hp_q == NONE_ID && !irq_q));
  assert_line_needs_id_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (hp_q != NONE_ID));
  assert_masked_hidden_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (last_step && !restart && gate_en && !publish) |=> (hp_q == NONE_ID && !irq_q));
  assert_hold_midscan_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_step && gate_en) |=> ($stable(hp_q) && $stable(irq_q)));
  assert_done_low_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !done_q);
  assert_restart_clears_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!done_q && busy_q && idx_q == '0));
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int NUM_CPU = 2,
  parameter int SCAN_W  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       dist_en,
  input  logic [NUM_CPU-1:0]         cpu_if_en,
  input  logic [NUM_CPU*NUM_IRQ-1:0] irq_enable,
  input  logic [NUM_CPU*NUM_IRQ-1:0] irq_pending,
  input  logic [NUM_IRQ*PRIO_W-1:0]  irq_prio,
  input  logic [NUM_CPU*PRIO_W-1:0]  prio_mask,
  input  logic [NUM_CPU*RUN_W-1:0]   run_prio,
  output logic [NUM_CPU*ID_W-1:0]    hp_id,
  output logic [NUM_CPU-1:0]         irq_req,
  output logic [NUM_CPU-1:0]         scan_done
);
  localparam int WATCH_W = 1 + NUM_CPU * (1 + 2 * NUM_IRQ + PRIO_W + RUN_W)
                           + NUM_IRQ * PRIO_W;

  logic any_change;

  irq_change_detect #(.W(WATCH_W)) chg_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .vec     ({dist_en, cpu_if_en, irq_enable, irq_pending,
               irq_prio, prio_mask, run_prio}),
    .changed (any_change)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    irq_cpu_scan #(.NUM_IRQ(NUM_IRQ), .SCAN_W(SCAN_W)) scan_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (any_change),
      .gate_en  (dist_en && cpu_if_en[c]),
      .enable   (irq_enable[c*NUM_IRQ +: NUM_IRQ]),
      .pending  (irq_pending[c*NUM_IRQ +: NUM_IRQ]),
      .prio     (irq_prio),
      .mask     (prio_mask[c*PRIO_W +: PRIO_W]),
      .run_prio (run_prio[c*RUN_W +: RUN_W]),
      .hp_id    (hp_id[c*ID_W +: ID_W]),
      .irq_req  (irq_req[c]),
      .done     (scan_done[c])
    );
  end
endmodule

// File: tb/irq_prio_arbiter_tb_top.sv
module irq_prio_arbiter_tb_top;
  localparam int NI = 32;
  localparam int NC = 2;
  localparam int SW = 4;
  localparam int LAT = NI / SW + 1;

  typedef struct {
    logic [NC*10-1:0] hp;
    logic [NC-1:0]    irq;
    logic [NC-1:0]    on;
    string            tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dist_en = 1'b1;
  logic [NC-1:0] cpu_en = '1;
  logic [NC*NI-1:0] en = '1;
  logic [NC*NI-1:0] pend = '0;
  logic [NI*8-1:0] prio;
  logic [NC*8-1:0] mask = {NC{8'hFF}};
  logic [NC*9-1:0] run = {NC{9'h100}};
  logic [NC*10-1:0] hp_id;
  logic [NC-1:0] irq_req;
  logic [NC-1:0] scan_done;

  item_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  logic [NC*10-1:0] last_hp = {NC{10'd1023}};
  logic [NC-1:0] last_irq = '0;

  always #2 clk = ~clk;

  irq_prio_arbiter #(.NUM_IRQ(NI), .NUM_CPU(NC), .SCAN_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .cpu_if_en(cpu_en),
    .irq_enable(en), .irq_pending(pend), .irq_prio(prio),
    .prio_mask(mask), .run_prio(run), .hp_id(hp_id),
    .irq_req(irq_req), .scan_done(scan_done)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // independent reference model and driver
  task automatic apply(input string tag);
    item_t it;
    for (int c = 0; c < NC; c++) begin
      int best = 256;
      int id = 1023;
      it.hp[c*10 +: 10] = 10'd1023;
      it.irq[c] = 1'b0;
      it.on[c] = dist_en && cpu_en[c];
      if (it.on[c]) begin
        for (int i = 0; i < NI; i++)
          if (en[c*NI+i] && pend[c*NI+i] && int'(prio[i*8 +: 8]) < best) begin
            best = int'(prio[i*8 +: 8]);
            id = i;
          end
        if (best < int'(mask[c*8 +: 8])) begin
          it.hp[c*10 +: 10] = 10'(id);
          it.irq[c] = (best < int'(run[c*9 +: 9]));
        end
      end
    end
    it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  // monitor: pops expected items and compares as results emerge
  initial begin
    forever begin
      item_t it;
      int n;
      wait (q.size() > 0);
      it = q[0];
      @(posedge clk);
      @(negedge clk);
      n = 1;
      for (int c = 0; c < NC; c++) begin
        if (it.on[c]) begin
          check({it.tag, " R9 hold id"}, int'(hp_id[c*10 +: 10]), int'(last_hp[c*10 +: 10]));
          check({it.tag, " R9 hold irq"}, int'(irq_req[c]), int'(last_irq[c]));
        end else begin
          check({it.tag, " R4 early id"}, int'(hp_id[c*10 +: 10]), 1023);
          check({it.tag, " R4 early irq"}, int'(irq_req[c]), 0);
        end
      end
      check({it.tag, " R8 done low"}, int'(scan_done), 0);
      while (!(&scan_done)) begin
        @(negedge clk);
        n++;
      end
      check({it.tag, " R8 latency"}, n, LAT);
      for (int c = 0; c < NC; c++) begin
        check({it.tag, " id"}, int'(hp_id[c*10 +: 10]), int'(it.hp[c*10 +: 10]));
        check({it.tag, " irq"}, int'(irq_req[c]), int'(it.irq[c]));
      end
      last_hp = it.hp;
      last_irq = it.irq;
      void'(q.pop_front());
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    for (int i = 0; i < NI; i++) prio[i*8 +: 8] = 8'h80;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < NC; c++) begin
      check("R11 reset id", int'(hp_id[c*10 +: 10]), 1023);
      check("R11 reset irq", int'(irq_req[c]), 0);
    end
    repeat (20) @(negedge clk);

    prio[5*8 +: 8] = 8'h40; prio[9*8 +: 8] = 8'h20;
    pend[5] = 1'b1; pend[9] = 1'b1; pend[NI+30] = 1'b1;
    apply("R1 R10 lowest value");

    @(negedge clk);
    pend = '0;
    prio[3*8 +: 8] = 8'h10; prio[20*8 +: 8] = 8'h10;
    pend[3] = 1'b1; pend[20] = 1'b1; pend[NI+20] = 1'b1;
    apply("R2 tie lowest id");

    @(negedge clk);
    en[3] = 1'b0; en[20] = 1'b0;
    apply("R3 not enabled");

    @(negedge clk);
    en = '1; pend = '0;
    prio[12*8 +: 8] = 8'h30; pend[12] = 1'b1;
    mask[7:0] = 8'h30;
    apply("R5 mask equal");

    @(negedge clk);
    mask[7:0] = 8'h31;
    apply("R5 R7 mask above");

    @(negedge clk);
    run[8:0] = 9'h030;
    apply("R6 running equal");

    @(negedge clk);
    run[8:0] = 9'h031;
    apply("R6 running above");

    @(negedge clk);
    dist_en = 1'b0;
    apply("R4 distributor off");

    @(negedge clk);
    dist_en = 1'b1; cpu_en[1] = 1'b0; pend[NI+7] = 1'b1;
    apply("R4 cpu1 off");

    @(negedge clk);
    prio[31*8 +: 8] = 8'h00; pend[31] = 1'b1;
    apply("R1 last group");

    @(negedge clk);
    cpu_en[1] = 1'b1; mask[15:8] = 8'h10;
    apply("R10 cpu1 own mask");

    @(negedge clk);
    mask[15:8] = 8'hFF; run[17:9] = 9'h080;
    apply("R10 R6 cpu1 running");

    finish_run();
  end
endmodule